// File: doc/BRIEF.md
# Programmable RGB to YCbCr Converter

This block converts a stream of 8-bit-per-channel RGB pixels into 8-bit Y, Cb and Cr samples for the output stage of a display mixer. Each output channel is a signed dot product of the input pixel with one row of a programmable 3x3 matrix. The products are summed and rounded, then an offset is added and the result is clamped to the video-legal range. The datapath is a three-stage pipeline, and the valid flag travels alongside the data.

Configuration is written one 32-bit word at a time into shadow registers through a register-write port. The shadow set is copied into the active set only on a frame-start pulse, so a frame is never converted with a half-updated matrix. A full-range flag in the luma row word sets how the input is treated. When it is clear, the input is taken as 16..235 studio range and is stretched to 0..255 before the matrix is applied. In every cycle with no valid result, the outputs carry a programmable background colour.

Top module: `csc_rgb2ycc`

## Requirements
- R1: After reset the output is not valid and shows the background Y=0x00, Cb=0x80, Cr=0x80. The active matrix holds luma codes 0x05E/0x13A/0x020, blue-difference codes 0x3CC/0x353/0x0E1 and red-difference codes 0x0E1/0x334/0x3EC, and the full-range flag is set.
- R2: Address 0 holds the Y row, address 1 the Cb row and address 2 the Cr row. In a row word, bits 29:20 weight R, bits 19:10 weight G and bits 9:0 weight B. Each weight is a 10-bit two's-complement code whose value is the code divided by 512.
- R3: For each row, S = cR*R + cG*G + cB*B, counted in units of 1/512. The rounded value is floor((S + 256) / 512). Y adds 16, and Cb and Cr add 128.
- R4: Y is clamped to 16..235, and Cb and Cr are clamped to 16..240.
- R5: Bit 30 of the Y row word is the full-range flag. When it is 1, R, G and B enter the matrix unchanged. When it is 0, each channel x becomes 0 if x < 16, and otherwise min(255, floor(((x-16)*298 + 128) / 256)).
- R6: A pixel sampled on one rising edge appears, with the valid output high, after the second rising edge that follows. Every input pixel yields exactly one output, in input order.
- R7: Configuration writes change only the shadow set. A frame-start pulse copies the shadow set into the active set on its edge. A pixel sampled on that same edge or earlier is converted with the previous active set.
- R8: Address 3 holds the background as Y at bits 23:16, Cb at bits 15:8 and Cr at bits 7:0. While the valid output is low, the outputs show the active background as it stood one cycle earlier.
- R9: Bit 31 of every word and bits 31:24 of the background word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word address (0 Y row, 1 Cb row, 2 Cr row, 3 background) |
| cfg_wdata_i | input | 32 | Configuration write data |
| frame_start_i | input | 1 | Copies the shadow configuration into the active set |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | 8 | Red sample |
| pix_g_i | input | 8 | Green sample |
| pix_b_i | input | 8 | Blue sample |
| ycc_valid_o | output | 1 | Output sample valid |
| ycc_y_o | output | 8 | Luma, or the background luma when not valid |
| ycc_cb_o | output | 8 | Blue difference, or the background value when not valid |
| ycc_cr_o | output | 8 | Red difference, or the background value when not valid |

## Verification
The default matrix is first driven with black, white, the three primaries and two mixed pixels. This catches sign and rounding faults, because white must land exactly on the top of the luma range while its chroma cancels to 128. Sparse matrices with a single non-zero weight per row then show whether each field weights the right colour and whether a negative code is sign-extended. All-maximum and all-minimum matrices push every channel past both clamp limits. A grey ramp with the full-range flag cleared separates the stretched path from the direct one at the 16 and 235 knees. Writes held back from a frame start, together with a pixel sampled one edge before a frame start, show that configuration is applied only at the frame boundary.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W    = 8;
  localparam int COEF_W   = 10;
  localparam int FRAC_W   = COEF_W - 1;
  localparam int N_CH     = 3;
  localparam int REG_W    = 32;
  localparam int ROW_W    = N_CH * COEF_W;
  localparam int FULL_BIT = ROW_W;
  localparam int BG_W     = N_CH * PIX_W;
  localparam int ADDR_W   = $clog2(N_CH + 1);
  localparam int PROD_W   = COEF_W + PIX_W + 1;
  localparam int SUM_W    = PROD_W + $clog2(N_CH);

  localparam int Y_OFS   = 16;
  localparam int C_OFS   = 128;
  localparam int OUT_MIN = 16;
  localparam int Y_MAX   = 235;
  localparam int C_MAX   = 240;

  // studio-range stretch: (x - LIM_LO) * EXP_MUL / 2^EXP_SH
  localparam int LIM_LO  = 16;
  localparam int EXP_MUL = 298;
  localparam int EXP_SH  = 8;
  localparam int EXP_W   = PIX_W + 9;

  localparam logic [ADDR_W-1:0] ADDR_BG = ADDR_W'(N_CH);

  typedef logic [ROW_W-1:0] row_t;

  typedef struct packed {
    logic                        full;
    logic [BG_W-1:0]             bg;
    logic [N_CH-1:0][ROW_W-1:0]  rows;   // [0]=Y [1]=Cb [2]=Cr
  } csc_cfg_t;

  localparam row_t ROW_Y_DEF  = {10'h05E, 10'h13A, 10'h020};
  localparam row_t ROW_CB_DEF = {10'h3CC, 10'h353, 10'h0E1};
  localparam row_t ROW_CR_DEF = {10'h0E1, 10'h334, 10'h3EC};
  localparam logic [BG_W-1:0] BG_DEF = 24'h008080;

  localparam csc_cfg_t CFG_DEF = '{
    full: 1'b1,
    bg:   BG_DEF,
    rows: {ROW_CR_DEF, ROW_CB_DEF, ROW_Y_DEF}
  };

  function automatic int row_ofs(int i);
    return (i == 0) ? Y_OFS : C_OFS;
  endfunction

  function automatic int row_max(int i);
    return (i == 0) ? Y_MAX : C_MAX;
  endfunction
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
  import csc_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [REG_W-1:0]           wdata_i,
  input  logic                       frame_start_i,
  output logic [N_CH-1:0][ROW_W-1:0] rows_o,
  output logic                       full_o,
  output logic [BG_W-1:0]            bg_o
);
  csc_cfg_t shd_q, act_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[REG_W-1:FULL_BIT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= CFG_DEF;
      act_q <= CFG_DEF;
    end else begin
      if (we_i) begin
        if (addr_i == ADDR_BG) begin
          shd_q.bg <= wdata_i[BG_W-1:0];
        end else begin
          shd_q.rows[addr_i] <= wdata_i[ROW_W-1:0];
          if (addr_i == '0) shd_q.full <= wdata_i[FULL_BIT];
        end
      end
      if (frame_start_i) act_q <= shd_q;
    end
  end

  assign rows_o = act_q.rows;
  assign full_o = act_q.full;
  assign bg_o   = act_q.bg;

  // R7
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_q));

  // R7
  act_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> act_q == $past(shd_q));

  // R8
  bg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_BG) |=> shd_q.bg == $past(wdata_i[BG_W-1:0]));
endmodule

// File: rtl/csc_range_expand.sv
module csc_range_expand
  import csc_pkg::*;
(
  input  logic             full_i,
  input  logic [PIX_W-1:0] px_i,
  output logic [PIX_W-1:0] px_o
);
  localparam int EXP_RND = 1 << (EXP_SH - 1);
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  logic [PIX_W-1:0] base;
  logic [EXP_W-1:0] scaled;

  always_comb begin
    base = '0;
    if (px_i >= PIX_W'(LIM_LO)) base = px_i - PIX_W'(LIM_LO);
    scaled = (EXP_W'(base) * EXP_W'(EXP_MUL) + EXP_W'(EXP_RND)) >> EXP_SH;
    if (full_i)                          px_o = px_i;
    else if (scaled > EXP_W'(PIX_MAX))   px_o = '1;
    else                                 px_o = scaled[PIX_W-1:0];
  end
endmodule

// File: rtl/csc_row_mac.sv
module csc_row_mac
  import csc_pkg::*;
#(
  parameter int               OFS = 16,
  parameter int               LO  = 16,
  parameter int               HI  = 235,
  parameter logic [PIX_W-1:0] RST = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CH-1:0][PIX_W-1:0] px_i,     // [0]=R [1]=G [2]=B
  input  logic [ROW_W-1:0]           coefs_i,
  input  logic                       pix_sel_i,
  input  logic [PIX_W-1:0]           bg_i,
  output logic [PIX_W-1:0]           res_o
);
  localparam logic signed [SUM_W-1:0] RND  = SUM_W'(1 << (FRAC_W - 1));
  localparam logic signed [SUM_W-1:0] OFSV = SUM_W'(OFS);
  localparam logic signed [SUM_W-1:0] LOV  = SUM_W'(LO);
  localparam logic signed [SUM_W-1:0] HIV  = SUM_W'(HI);
  localparam logic [PIX_W-1:0]        LO_P = PIX_W'(LO);
  localparam logic [PIX_W-1:0]        HI_P = PIX_W'(HI);

  logic signed [PROD_W-1:0] prod_d [N_CH];
  logic signed [PROD_W-1:0] prod_q [N_CH];
  logic signed [SUM_W-1:0]  sum_d, sum_q, rnd, ofs;
  logic [PIX_W-1:0]         clamp_d;

  for (genvar k = 0; k < N_CH; k++) begin : g_mul
    logic signed [COEF_W-1:0] c;
    assign c = coefs_i[(N_CH-1-k)*COEF_W +: COEF_W];
    assign prod_d[k] = PROD_W'(c) * PROD_W'($signed({1'b0, px_i[k]}));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q[k] <= '0;
      else         prod_q[k] <= prod_d[k];
    end
  end

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < N_CH; k++) sum_d = sum_d + SUM_W'(prod_q[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_d;
  end

  always_comb begin
    rnd = (sum_q + RND) >>> FRAC_W;
    ofs = rnd + OFSV;
    if (ofs < LOV)      clamp_d = LO_P;
    else if (ofs > HIV) clamp_d = HI_P;
    else                clamp_d = ofs[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= RST;
    else         res_o <= pix_sel_i ? clamp_d : bg_i;
  end

  // R4
  clamp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_sel_i |=> (res_o >= LO_P && res_o <= HI_P));
endmodule

// File: rtl/csc_rgb2ycc.sv
module csc_rgb2ycc
  import csc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_addr_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        frame_start_i,
  input  logic        pix_valid_i,
  input  logic [7:0]  pix_r_i,
  input  logic [7:0]  pix_g_i,
  input  logic [7:0]  pix_b_i,
  output logic        ycc_valid_o,
  output logic [7:0]  ycc_y_o,
  output logic [7:0]  ycc_cb_o,
  output logic [7:0]  ycc_cr_o
);
  localparam int LAT = 3;

  logic [N_CH-1:0][ROW_W-1:0] rows;
  logic                       full;
  logic [BG_W-1:0]            bg;
  logic [N_CH-1:0][PIX_W-1:0] px_raw, px_exp;
  logic [N_CH-1:0][PIX_W-1:0] res;
  logic [LAT-1:0]             vld_q;

  csc_cfg_regs u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (cfg_we_i),
    .addr_i        (cfg_addr_i),
    .wdata_i       (cfg_wdata_i),
    .frame_start_i (frame_start_i),
    .rows_o        (rows),
    .full_o        (full),
    .bg_o          (bg)
  );

  assign px_raw = {pix_b_i, pix_g_i, pix_r_i};

  for (genvar k = 0; k < N_CH; k++) begin : g_exp
    csc_range_expand u_exp (
      .full_i (full),
      .px_i   (px_raw[k]),
      .px_o   (px_exp[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], pix_valid_i};
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_row
    csc_row_mac #(
      .OFS (row_ofs(i)),
      .LO  (OUT_MIN),
      .HI  (row_max(i)),
      .RST (BG_DEF[(N_CH-1-i)*PIX_W +: PIX_W])
    ) u_row (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .px_i      (px_exp),
      .coefs_i   (rows[i]),
      .pix_sel_i (vld_q[LAT-2]),
      .bg_i      (bg[(N_CH-1-i)*PIX_W +: PIX_W]),
      .res_o     (res[i])
    );
  end

  assign ycc_valid_o = vld_q[LAT-1];
  assign ycc_y_o     = res[0];
  assign ycc_cb_o    = res[1];
  assign ycc_cr_o    = res[2];

  // R6
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |-> ##3 ycc_valid_o);

  // R6
  idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |-> ##3 !ycc_valid_o);

  // R8
  bg_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ycc_valid_o |-> {ycc_y_o, ycc_cb_o, ycc_cr_o} == $past(bg));
endmodule

// File: tb/tb_csc_rgb2ycc.sv
`timescale 1ns/1ps
module tb_csc_rgb2ycc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
  logic        ycc_valid;
  logic [7:0]  ycc_y, ycc_cb, ycc_cr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cyc = 0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  // bench model of configuration
  int m_shd_row[3], m_act_row[3];
  bit m_shd_full, m_act_full;
  int m_shd_bg, m_act_bg;

  always #2 clk = ~clk;

  csc_rgb2ycc dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cfg_we_i      (cfg_we),
    .cfg_addr_i    (cfg_addr),
    .cfg_wdata_i   (cfg_wdata),
    .frame_start_i (frame_start),
    .pix_valid_i   (pix_valid),
    .pix_r_i       (pix_r),
    .pix_g_i       (pix_g),
    .pix_b_i       (pix_b),
    .ycc_valid_o   (ycc_valid),
    .ycc_y_o       (ycc_y),
    .ycc_cb_o      (ycc_cb),
    .ycc_cr_o      (ycc_cr)
  );

  function automatic int sx10(int code);
    return (code >= 512) ? code - 1024 : code;
  endfunction

  function automatic int stretch(int x);
    int v;
    if (x < 16) return 0;
    v = ((x - 16) * 298 + 128) >> 8;
    return (v > 255) ? 255 : v;
  endfunction

  function automatic logic [23:0] model(int r, int g, int b);
    int px[3];
    logic [23:0] res;
    px[0] = r; px[1] = g; px[2] = b;
    if (!m_act_full) for (int k = 0; k < 3; k++) px[k] = stretch(px[k]);
    for (int i = 0; i < 3; i++) begin
      int s, v, hi;
      s = 0;
      for (int k = 0; k < 3; k++)
        s += sx10((m_act_row[i] >> ((2 - k) * 10)) & 10'h3FF) * px[k];
      v = ((s + 256) >>> 9) + ((i == 0) ? 16 : 128);
      hi = (i == 0) ? 235 : 240;
      if (v < 16) v = 16;
      if (v > hi) v = hi;
      res[(2 - i) * 8 +: 8] = 8'(v);
    end
    return res;
  endfunction

  function automatic int row(int c0, int c1, int c2);
    return (c0 << 20) | (c1 << 10) | c2;
  endfunction

  task automatic chk(string tag, logic [23:0] got, logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %06h expected %06h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 1'b0; frame_start = 1'b0; pix_valid = 1'b0;
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = data;
    frame_start = 1'b0; pix_valid = 1'b0;
    if (addr == 3) m_shd_bg = int'(data[23:0]);
    else begin
      m_shd_row[addr] = int'(data[29:0]);
      if (addr == 0) m_shd_full = data[30];
    end
  endtask

  task automatic fs();
    @(negedge clk);
    cfg_we = 1'b0; frame_start = 1'b1; pix_valid = 1'b0;
    m_act_row = m_shd_row; m_act_full = m_shd_full; m_act_bg = m_shd_bg;
  endtask

  task automatic pix(string tag, int r, int g, int b);
    @(negedge clk);
    cfg_we = 1'b0; frame_start = 1'b0; pix_valid = 1'b1;
    pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
    exp_q.push_back(model(r, g, b));
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ycc_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: got %06h expected no output", {ycc_y, ycc_cb, ycc_cr});
      end else begin
        string t;
        logic [23:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {ycc_y, ycc_cb, ycc_cr}, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_shd_row[0] = row('h05E, 'h13A, 'h020);
    m_shd_row[1] = row('h3CC, 'h353, 'h0E1);
    m_shd_row[2] = row('h0E1, 'h334, 'h3EC);
    m_shd_full = 1'b1;
    m_shd_bg = 'h008080;
    m_act_row = m_shd_row; m_act_full = m_shd_full; m_act_bg = m_shd_bg;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state
    chk("R1", {23'd0, ycc_valid}, 24'd0);
    chk("R1", {ycc_y, ycc_cb, ycc_cr}, 24'h008080);

    // R1 R3: default matrix
    pix("R1", 0, 0, 0);
    pix("R3", 255, 255, 255);
    pix("R3", 255, 0, 0);
    pix("R3", 0, 255, 0);
    pix("R3", 0, 0, 255);
    pix("R3", 12, 200, 77);
    pix("R3", 250, 3, 128);
    idle(1);
    pix("R6", 90, 60, 30);
    idle(5);
    // R8: background between pixels
    chk("R8", {ycc_y, ycc_cb, ycc_cr}, 24'h008080);

    // R7: write without frame start has no effect
    wr(0, 32'h4000_0000 | 32'(row('h100, 0, 0)));
    pix("R7", 200, 100, 50);
    idle(4);
    fs();
    pix("R7", 200, 100, 50);
    idle(4);

    // R2: field positions and sign
    wr(0, 32'h4000_0000 | 32'(row(0, 'h100, 0)));
    wr(1, 32'(row(0, 0, 'h0FF)));
    wr(2, 32'(row('h380, 0, 0)));
    fs();
    pix("R2", 200, 0, 0);
    pix("R2", 0, 200, 0);
    pix("R2", 0, 0, 200);
    pix("R2", 40, 180, 220);
    idle(4);

    // R4: clamping both ways
    wr(0, 32'h4000_0000 | 32'(row('h1FF, 'h1FF, 'h1FF)));
    wr(1, 32'(row('h201, 'h201, 'h201)));
    wr(2, 32'(row('h1FF, 'h1FF, 'h1FF)));
    fs();
    pix("R4", 255, 255, 255);
    pix("R4", 0, 0, 0);
    pix("R4", 30, 20, 10);
    idle(4);

    // R5: studio range input with default matrix
    wr(0, 32'(row('h05E, 'h13A, 'h020)));
    wr(1, 32'(row('h3CC, 'h353, 'h0E1)));
    wr(2, 32'(row('h0E1, 'h334, 'h3EC)));
    fs();
    pix("R5", 0, 0, 0);
    pix("R5", 10, 10, 10);
    pix("R5", 16, 16, 16);
    pix("R5", 235, 235, 235);
    pix("R5", 255, 255, 255);
    pix("R5", 100, 150, 200);
    idle(4);

    // R8 R9: background change, top byte ignored
    wr(3, 32'hFF12_3456);
    idle(3);
    chk("R7", {ycc_y, ycc_cb, ycc_cr}, 24'h008080);
    fs();
    idle(3);
    chk("R9", {ycc_y, ycc_cb, ycc_cr}, 24'h123456);
    chk("R8", {23'd0, ycc_valid}, 24'd0);

    // R7: pixel one edge before frame start uses old set
    wr(0, 32'hC000_0000 | 32'(row('h05E, 'h13A, 'h020)));
    pix("R7", 100, 150, 200);
    fs();
    pix("R7", 100, 150, 200);
    pix("R6", 1, 2, 3);
    idle(6);

    // R6: no missing outputs
    chk("R6", 24'(exp_q.size()), 24'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule